// File: doc/BRIEF.md
# Receive FIFO with Trigger Level

This block is the receive-side byte queue of a serial port. A deserialiser upstream offers one byte per strobe. A register read of the receive data location removes the oldest byte. The queue holds sixteen bytes in a ring, and its occupancy is always visible on an output so that software can read it as a count register.

A two-bit field of the FIFO control byte selects a fill threshold. When a stored byte brings the occupancy up to that threshold or past it, the block raises a receive-full flag. If the receive interrupt is enabled at that moment, the interrupt line goes high as well. Removing bytes until the occupancy drops below the threshold lowers the flag. Writing the control byte with its flush bit set empties the queue at once.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the occupancy is 0, the receive-full flag and the interrupt are low, the read data is 0 and the threshold is 1 entry.
- R2: Bytes leave in the order they arrived. Up to 16 are held, and the ring pointers wrap from the last slot back to the first with no loss or reordering.
- R3: A byte offered while 16 bytes are held is dropped. The occupancy stays at 16 and the stored bytes are unchanged.
- R4: A read request on an empty queue presents 0 on the read data and leaves the occupancy, the flag and the interrupt unchanged.
- R5: Control byte bits [7:6] set the threshold on any control write: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 entries.
- R6: The flag is set in the cycle after an accepted byte when the new occupancy is at or above the threshold.
- R7: The flag is cleared in the cycle after a read when the new occupancy is below the threshold. A threshold change alone does not re-evaluate the flag.
- R8: The interrupt rises together with a flag-setting push if the enable input is high. It falls in the cycle after the enable is low, and it falls when the flag clears.
- R9: A control write with bit 1 set empties the queue and resets both pointers, the flag and the interrupt. It wins over a push or read in the same cycle.
- R10: A push and a read in the same cycle with an occupancy between 1 and 15 both take effect, so the occupancy is unchanged. At 16 the push is dropped and the occupancy becomes 15. At 0 the read is ignored and the occupancy becomes 1.
- R11: The occupancy output equals the number of bytes held after every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Receive strobe: store push_data_i |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Receive data read: remove the oldest byte |
| pop_data_o | output | 8 | Oldest byte, 0 when empty |
| cfg_wr_i | input | 1 | FIFO control byte write strobe |
| cfg_data_i | input | 8 | FIFO control byte: [7:6] threshold select, [1] flush |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| fill_o | output | 5 | Number of bytes held |
| rx_full_o | output | 1 | Receive-full flag: occupancy reached the threshold |
| irq_o | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is a ring whose pointers sit mid-array when the queue runs completely full. A full-queue push and read must then act on the wrapped slots. The stimulus first moves both pointers around by filling and draining a partial load. It then fills to 16 and offers an extra byte, and makes a simultaneous push and read at full. A scoreboard queue checks every byte that comes out against the order in which bytes were accepted. The sticky nature of the flag under a threshold change is reached by lowering the threshold with no flush while the flag is low. The bench then confirms the flag stays low until the next push.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Threshold select field of the FIFO control byte (bits [7:6])
  typedef enum logic [1:0] {
    LVL_SEL_MIN  = 2'b00,
    LVL_SEL_QTR  = 2'b01,
    LVL_SEL_HALF = 2'b10,
    LVL_SEL_NEAR = 2'b11
  } lvl_sel_e;

  // FIFO control byte layout
  typedef struct packed {
    logic [1:0] lvl_sel;   // [7:6] threshold select
    logic [3:0] spare_hi;  // [5:2]
    logic       flush;     // [1]   empty the queue
    logic       spare_lo;  // [0]
  } fifo_ctrl_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          clr_i,
  output logic [DW-1:0] head_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic          wr_ptr_en, rd_ptr_en;
  logic [DEPTH-1:0][DW-1:0] slot_w;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_en = clr_i | wr_en_i;
    rd_ptr_en = clr_i | rd_en_i;
    wr_ptr_d  = clr_i ? '0 : ptr_inc(wr_ptr_q);
    rd_ptr_d  = clr_i ? '0 : ptr_inc(rd_ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_ptr_en) wr_ptr_q <= wr_ptr_d;
      if (rd_ptr_en) rd_ptr_q <= rd_ptr_d;
    end
  end

  // One data register per slot; datapath storage carries no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic          slot_en;
    assign slot_en = wr_en_i & ~clr_i & (wr_ptr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wr_data_i;
    end
    assign slot_w[g] = slot_q;
  end

  assign head_o = slot_w[rd_ptr_q];

endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  input  logic          flush_i,
  input  logic          cfg_wr_i,
  input  lvl_sel_e      lvl_sel_i,
  input  logic          irq_en_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o,
  output logic          irq_o
);

  logic [CW-1:0] cnt_q, cnt_d, lvl_q, lvl_d;
  logic          cnt_en, lvl_en;
  logic          flag_q, flag_d, irq_q, irq_d;
  logic          set_evt, clr_evt;

  function automatic logic [CW-1:0] lvl_decode(input lvl_sel_e s);
    case (s)
      LVL_SEL_MIN:  return CW'(LVL0);
      LVL_SEL_QTR:  return CW'(LVL1);
      LVL_SEL_HALF: return CW'(LVL2);
      default:      return CW'(LVL3);
    endcase
  endfunction

  always_comb begin
    push_ok_o = push_req_i & ~flush_i & (cnt_q < CW'(DEPTH));
    pop_ok_o  = pop_req_i & ~flush_i & (cnt_q != '0);
    cnt_en    = flush_i | push_ok_o | pop_ok_o;
    cnt_d     = flush_i ? '0 : cnt_q + CW'(push_ok_o) - CW'(pop_ok_o);
    lvl_en    = cfg_wr_i;
    lvl_d     = lvl_decode(lvl_sel_i);
    set_evt   = push_ok_o & (cnt_d >= lvl_q);
    clr_evt   = pop_ok_o & (cnt_d < lvl_q);
    if (flush_i)      flag_d = 1'b0;
    else if (set_evt) flag_d = 1'b1;
    else if (clr_evt) flag_d = 1'b0;
    else              flag_d = flag_q;
    if (flush_i)                  irq_d = 1'b0;
    else if (set_evt && irq_en_i) irq_d = 1'b1;
    else if (!irq_en_i || !flag_d) irq_d = 1'b0;
    else                          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= CW'(LVL0);
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lvl_en) lvl_q <= lvl_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              pop_data_o,
  input  logic                       cfg_wr_i,
  input  logic [7:0]                 cfg_data_i,
  input  logic                       rx_irq_en_i,
  output logic [$clog2(DEPTH+1)-1:0] fill_o,
  output logic                       rx_full_o,
  output logic                       irq_o
);

  localparam int CW = $clog2(DEPTH + 1);

  fifo_ctrl_t    ctrl;
  logic          flush;
  logic          push_ok, pop_ok;
  logic [CW-1:0] cnt;
  logic [DW-1:0] head;
  logic          unused_ctrl_bits;

  assign ctrl             = fifo_ctrl_t'(cfg_data_i);
  assign flush            = cfg_wr_i & ctrl.flush;
  assign unused_ctrl_bits = ^{ctrl.spare_hi, ctrl.spare_lo};

  rxq_level #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req_i (push_i),
    .pop_req_i  (pop_i),
    .flush_i    (flush),
    .cfg_wr_i   (cfg_wr_i),
    .lvl_sel_i  (lvl_sel_e'(ctrl.lvl_sel)),
    .irq_en_i   (rx_irq_en_i),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .cnt_o      (cnt),
    .flag_o     (rx_full_o),
    .irq_o      (irq_o)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (push_ok),
    .wr_data_i (push_data_i),
    .rd_en_i   (pop_ok),
    .clr_i     (flush),
    .head_o    (head)
  );

  assign pop_data_o = (cnt != '0) ? head : '0;
  assign fill_o     = cnt;

endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push_i,
  input logic                       pop_i,
  input logic [DW-1:0]              pop_data_o,
  input logic                       cfg_wr_i,
  input logic [7:0]                 cfg_data_i,
  input logic                       rx_irq_en_i,
  input logic [$clog2(DEPTH+1)-1:0] fill_o,
  input logic                       rx_full_o,
  input logic                       irq_o
);

  logic flush_req;
  assign flush_req = cfg_wr_i & cfg_data_i[1];

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= ($clog2(DEPTH+1))'(DEPTH)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == ($clog2(DEPTH+1))'(DEPTH) && push_i && !pop_i && !flush_req)
      |=> fill_o == ($clog2(DEPTH+1))'(DEPTH)); // R3

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == '0 && pop_i && !push_i && !flush_req)
      |=> (fill_o == '0 && !rx_full_o && pop_data_o == '0)); // R4

  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full_o) |-> $past(pop_i || flush_req)); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> rx_full_o); // R8

  AST_IRQ_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq_en_i |=> !irq_o); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (fill_o == '0 && !rx_full_o && !irq_o)); // R9

  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !flush_req && fill_o != '0 &&
     fill_o != ($clog2(DEPTH+1))'(DEPTH)) |=> $stable(fill_o)); // R10

endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .pop_data_o  (pop_data_o),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_data_i  (cfg_data_i),
  .rx_irq_en_i (rx_irq_en_i),
  .fill_o      (fill_o),
  .rx_full_o   (rx_full_o),
  .irq_o       (irq_o)
);

// File: tb/test_serial_rx_queue.sv
`timescale 1ns/1ps
module test_serial_rx_queue;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic       pop_i = 1'b0;
  logic [7:0] pop_data_o;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_data_i = '0;
  logic       rx_irq_en_i = 1'b0;
  logic [4:0] fill_o;
  logic       rx_full_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // scoreboard model
  byte unsigned exp_q[$];
  int  m_lvl  = 1;
  bit  m_flag = 0;
  bit  m_irq  = 0;

  always #10 clk = ~clk; // 50 MHz

  serial_rx_queue i_serial_rx_queue (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .cfg_wr_i(cfg_wr_i),
    .cfg_data_i(cfg_data_i), .rx_irq_en_i(rx_irq_en_i), .fill_o(fill_o),
    .rx_full_o(rx_full_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  // Monitor: compares outputs against the model, then applies this cycle's inputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int  cnt;
      bit  flush, pu_ok, po_ok, set_e, clr_e;
      int  exp_d;
      cnt = exp_q.size();
      chk("R11 fill", fill_o, cnt);
      chk("R6 flag", rx_full_o, m_flag);
      chk("R8 irq", irq_o, m_irq);
      flush = cfg_wr_i && cfg_data_i[1];
      if (pop_i) begin
        exp_d = (cnt > 0) ? exp_q[0] : 0;
        chk((cnt > 0) ? "R2 order" : "R4 empty data", pop_data_o, exp_d);
      end
      if (flush) begin
        exp_q.delete();
        m_flag = 0;
        m_irq  = 0;
      end else begin
        pu_ok = push_i && cnt < 16;
        po_ok = pop_i && cnt > 0;
        if (po_ok) void'(exp_q.pop_front());
        if (pu_ok) exp_q.push_back(push_data_i);
        set_e = pu_ok && exp_q.size() >= m_lvl;
        clr_e = po_ok && exp_q.size() < m_lvl;
        if (set_e) m_flag = 1;
        else if (clr_e) m_flag = 0;
        if (set_e && rx_irq_en_i) m_irq = 1;
        else if (!rx_irq_en_i || !m_flag) m_irq = 0;
      end
      if (cfg_wr_i) m_lvl = lvl_of(cfg_data_i[7:6]);
    end
  end

  // Driver: one cycle of stimulus
  task automatic drive(input bit ps, input logic [7:0] d, input bit pp,
                       input bit cw, input logic [7:0] cd);
    push_i = ps; push_data_i = d; pop_i = pp; cfg_wr_i = cw; cfg_data_i = cd;
    @(posedge clk); #1;
    push_i = 0; pop_i = 0; cfg_wr_i = 0;
  endtask

  task automatic push(input logic [7:0] d); drive(1, d, 0, 0, 8'h00); endtask
  task automatic pop();                     drive(0, 8'h00, 1, 0, 8'h00); endtask
  task automatic flush_sel(input logic [1:0] s); drive(0, 8'h00, 0, 1, {s, 6'b000010}); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fill", fill_o, 0);
    chk("R1 flag", rx_full_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 data", pop_data_o, 0);
    @(posedge clk); #1;
    push(8'h5A);
    @(negedge clk); chk("R1 default threshold 1", rx_full_o, 1);
    pop();
    @(negedge clk); chk("R7 flag clear", rx_full_o, 0);

    // R4 read on empty
    @(posedge clk); #1;
    pop_i = 1;
    @(negedge clk); chk("R4 empty data", pop_data_o, 0);
    @(posedge clk); #1; pop_i = 0;
    @(negedge clk); chk("R4 fill", fill_o, 0);

    // R2 move pointers around, then fill completely
    @(posedge clk); #1;
    for (int i = 0; i < 9; i++) push(8'h10 + 8'(i));
    for (int i = 0; i < 9; i++) pop();
    for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i));
    @(negedge clk); chk("R2 full count", fill_o, 16);
    @(posedge clk); #1;
    push(8'hEE);
    @(negedge clk); chk("R3 drop at full", fill_o, 16);
    @(posedge clk); #1;
    drive(1, 8'hEF, 1, 0, 8'h00);
    @(negedge clk); chk("R10 push+pop at full", fill_o, 15);
    @(posedge clk); #1;
    for (int i = 0; i < 15; i++) pop();
    @(negedge clk); chk("R2 drained", fill_o, 0);
    @(posedge clk); #1;
    drive(1, 8'h77, 1, 0, 8'h00);
    @(negedge clk); chk("R10 push+pop at empty", fill_o, 1);
    @(posedge clk); #1;

    // R5 each threshold encoding
    for (int s = 0; s < 4; s++) begin
      int lv;
      lv = lvl_of(2'(s));
      flush_sel(2'(s));
      for (int k = 1; k <= lv; k++) begin
        push(8'(k * 3 + s));
        @(negedge clk); chk("R5 threshold", rx_full_o, (k >= lv) ? 1 : 0);
        @(posedge clk); #1;
      end
    end

    // R7 fall below threshold and sticky flag on threshold change
    flush_sel(2'b01);
    for (int i = 0; i < 5; i++) push(8'hC0 + 8'(i));
    pop();
    @(negedge clk); chk("R7 flag held at 4", rx_full_o, 1);
    @(posedge clk); #1;
    pop();
    @(negedge clk); chk("R7 flag clear at 3", rx_full_o, 0);
    @(posedge clk); #1;
    drive(0, 8'h00, 0, 1, 8'b00_0000_00);
    @(negedge clk); chk("R7 no re-evaluation", rx_full_o, 0);
    @(posedge clk); #1;
    push(8'hC9);
    @(negedge clk); chk("R6 set after push", rx_full_o, 1);
    @(posedge clk); #1;

    // R10 simultaneous push and read mid-level
    drive(1, 8'hD1, 1, 0, 8'h00);
    @(negedge clk); chk("R10 count held", fill_o, 4);
    @(posedge clk); #1;

    // R8 interrupt
    flush_sel(2'b01);
    rx_irq_en_i = 1;
    for (int i = 0; i < 4; i++) push(8'h30 + 8'(i));
    @(negedge clk); chk("R8 irq rise", irq_o, 1);
    @(posedge clk); #1;
    rx_irq_en_i = 0;
    @(posedge clk); #1;
    @(negedge clk); chk("R8 irq off with enable low", irq_o, 0);
    @(posedge clk); #1;
    rx_irq_en_i = 1;
    @(posedge clk); #1;
    @(negedge clk); chk("R8 irq stays low", irq_o, 0);
    @(posedge clk); #1;
    push(8'h34);
    @(negedge clk); chk("R8 irq on next push", irq_o, 1);
    @(posedge clk); #1;
    pop(); pop();
    @(negedge clk); chk("R8 irq off with flag", irq_o, 0);
    @(posedge clk); #1;
    push(8'h35);
    @(negedge clk); chk("R8 irq back", irq_o, 1);
    @(posedge clk); #1;

    // R9 flush wins over a same-cycle push
    drive(1, 8'h99, 0, 1, 8'b00_0000_10);
    @(negedge clk);
    chk("R9 fill", fill_o, 0);
    chk("R9 flag", rx_full_o, 0);
    chk("R9 irq", irq_o, 0);
    @(posedge clk); #1;
    push(8'h42);
    @(negedge clk); chk("R9 head after flush", pop_data_o, 8'h42);
    @(posedge clk); #1;
    pop();
    repeat (2) @(posedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule